// File: doc/BRIEF.md
# Triple-Pumped Replicated Register File

This block is the physical register file of an out-of-order pipeline. It offers four write ports and eight read ports per pipeline cycle, yet it is built only from plain dual-port synchronous RAMs. The block keeps four copies of the storage and every write goes to all of them, so the copies always hold the same contents. The block runs on a fast clock at three times the pipeline rate. Each pipeline cycle therefore holds three fast phases. The first two phases carry out the writes, two per phase. The third phase carries out the reads, with each copy serving two read ports.

The only clock the block receives is the fast clock. A pipeline-cycle boundary is a fast rising edge that lines up with a pipeline-clock rising edge. Reset holds the internal phase counter at zero, so the first fast edge after `rst_n` is released must be a boundary. After that, every third fast edge is a boundary. All request pins are sampled only at boundaries. The interfaces have no back-pressure: every port accepts a request in every pipeline cycle, so there is no ready signal. A read result is qualified by its own valid bit, and the consumer must take it during the pipeline cycle in which it is shown.

Top module: `tripump_regfile`

## Requirements
- R1: While reset is asserted, and for the first two pipeline cycles after reset is released, all `rd_valid` bits are 0.
- R2: Requests are sampled at boundary S. Their read results appear just after boundary S+1 and stay on the outputs until boundary S+2.
- R3: A read sampled at the same boundary as a write to the same register returns the newly written value.
- R4: Every enabled write lands in all four copies. A register gives the same data through any of the eight read ports.
- R5: The eight read ports work independently on any addresses. Read port i is served by copy i/2, on that copy's port i%2.
- R6: When two or more enabled writes sampled at the same boundary target one register, the value from the highest-numbered write port is stored.
- R7: A write port whose `wr_en` bit is 0 changes no register, whatever its address and data pins carry.
- R8: `rd_valid[i]` equals the `rd_en[i]` sampled one boundary earlier. When that bit was 0, `rd_data` of port i keeps the data of its last performed read.
- R9: `rd_data` and `rd_valid` change only at boundary edges. They are stable at every other fast edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, three times the pipeline clock, with rising edges aligned to it |
| rst_n | input | 1 | Asynchronous active-low reset; release just before a boundary edge |
| wr_en | input | 4 | Per-port write enable |
| wr_addr | input | 24 | Write addresses, port k at bits [6k+5:6k] |
| wr_data | input | 128 | Write data, port k at bits [32k+31:32k] |
| rd_en | input | 8 | Per-port read enable |
| rd_addr | input | 48 | Read addresses, port i at bits [6i+5:6i] |
| rd_data | output | 256 | Read data, port i at bits [32i+31:32i] |
| rd_valid | output | 8 | Read port i carries a result for the current pipeline cycle |

## Verification
Writes and reads can fall in the same pipeline cycle and touch the same register. That is the case where phase ordering matters. The bench provokes it in three ways. It writes four registers while reading them at the same boundary. It writes one register from several ports at once, both with and without a read of that register in the same cycle. It also runs randomized cycles whose addresses are squeezed into a narrow range so that overlaps happen often. A scoreboard applies the writes of each cycle in port order before it works out the reads of that cycle. It then expects the new value, the highest-port value, and the results exactly one boundary after sampling.

// File: rtl/tripump_pkg.sv
package tripump_pkg;

  // Each RAM copy has two physical ports.
  localparam int PORTS_PER_COPY = 2;

  // Phase in which write port k is executed (phase 0 is the read/boundary phase).
  function automatic int phase_of_write_port(int port);
    return port / PORTS_PER_COPY + 1;
  endfunction

  // RAM port of a copy used by write port k during its phase.
  function automatic int ram_port_of_write_port(int port);
    return port % PORTS_PER_COPY;
  endfunction

endpackage

// File: rtl/tripump_phase.sv
module tripump_phase #(
  parameter int PHASES = 3,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk_fast,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_q,
  output logic            boundary
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  // Held at zero in reset so the first edge after release is a boundary.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)
      ph_q <= '0;
    else if (ph_q == LAST)
      ph_q <= '0;
    else
      ph_q <= ph_q + 1'b1;
  end

  assign boundary = (ph_q == '0);
endmodule

// File: rtl/tripump_wr_filter.sv
module tripump_wr_filter #(
  parameter int WR_PORTS = 4,
  parameter int ADDR_W   = 6
) (
  input  logic [WR_PORTS-1:0]        en,
  input  logic [WR_PORTS*ADDR_W-1:0] addr,
  output logic [WR_PORTS-1:0]        kept
);
  // A write survives only if no higher-numbered enabled port hits the same entry.
  always_comb begin
    for (int k = 0; k < WR_PORTS; k++) begin
      kept[k] = en[k];
      for (int j = k + 1; j < WR_PORTS; j++) begin
        if (en[j] && (addr[j*ADDR_W +: ADDR_W] == addr[k*ADDR_W +: ADDR_W]))
          kept[k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tripump_ram.sv
module tripump_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int NPORTS = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic [NPORTS-1:0]          we,
  input  logic [NPORTS-1:0]          re,
  input  logic [NPORTS*ADDR_W-1:0]   addr,
  input  logic [NPORTS*DATA_W-1:0]   wd,
  output logic [NPORTS*DATA_W-1:0]   rd
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Synchronous storage; read registers hold their value when re is low.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (we[p])
        mem[addr[p*ADDR_W +: ADDR_W]] <= wd[p*DATA_W +: DATA_W];
      if (re[p])
        rd[p*DATA_W +: DATA_W] <= mem[addr[p*ADDR_W +: ADDR_W]];
    end
  end
endmodule

// File: rtl/tripump_regfile.sv
module tripump_regfile
  import tripump_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int COPIES    = 4,
  parameter int WR_PHASES = 2,
  localparam int WR_PORTS = WR_PHASES * PORTS_PER_COPY,
  localparam int RD_PORTS = COPIES * PORTS_PER_COPY
) (
  input  logic                       clk_fast,
  input  logic                       rst_n,
  input  logic [WR_PORTS-1:0]        wr_en,
  input  logic [WR_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [WR_PORTS*DATA_W-1:0] wr_data,
  input  logic [RD_PORTS-1:0]        rd_en,
  input  logic [RD_PORTS*ADDR_W-1:0] rd_addr,
  output logic [RD_PORTS*DATA_W-1:0] rd_data,
  output logic [RD_PORTS-1:0]        rd_valid
);
  localparam int PHASES = WR_PHASES + 1;
  localparam int PH_W   = $clog2(PHASES);
  localparam int PPC    = PORTS_PER_COPY;

  logic [PH_W-1:0]            ph_q;
  logic                       boundary;
  logic [WR_PORTS-1:0]        wr_kept;
  logic [WR_PORTS-1:0]        cap_wen_q;
  logic [WR_PORTS*ADDR_W-1:0] cap_waddr_q;
  logic [WR_PORTS*DATA_W-1:0] cap_wdata_q;
  logic [RD_PORTS-1:0]        cap_ren_q;
  logic [RD_PORTS*ADDR_W-1:0] cap_raddr_q;

  tripump_phase #(.PHASES(PHASES)) u_phase (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .ph_q     (ph_q),
    .boundary (boundary)
  );

  tripump_wr_filter #(.WR_PORTS(WR_PORTS), .ADDR_W(ADDR_W)) u_filter (
    .en   (wr_en),
    .addr (wr_addr),
    .kept (wr_kept)
  );

  // Boundary capture of the slow-domain requests and hand-back of read valid.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cap_wen_q <= '0;
      cap_ren_q <= '0;
      rd_valid  <= '0;
    end else if (boundary) begin
      cap_wen_q <= wr_kept;
      cap_ren_q <= rd_en;
      rd_valid  <= cap_ren_q;
    end
  end

  always_ff @(posedge clk_fast) begin
    if (boundary) begin
      cap_waddr_q <= wr_addr;
      cap_wdata_q <= wr_data;
      cap_raddr_q <= rd_addr;
    end
  end

  // One RAM copy per generate slot; writes broadcast, reads private.
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [PPC-1:0]        cp_we;
    logic [PPC-1:0]        cp_re;
    logic [PPC*ADDR_W-1:0] cp_addr;
    logic [PPC*DATA_W-1:0] cp_wd;
    logic [PPC*DATA_W-1:0] cp_rd;

    always_comb begin
      for (int p = 0; p < PPC; p++) begin
        cp_we[p] = 1'b0;
        cp_re[p] = boundary & cap_ren_q[c*PPC + p];
        cp_addr[p*ADDR_W +: ADDR_W] = cap_raddr_q[(c*PPC + p)*ADDR_W +: ADDR_W];
        cp_wd[p*DATA_W +: DATA_W]   = '0;
        for (int k = 0; k < WR_PORTS; k++) begin
          if ((ram_port_of_write_port(k) == p) &&
              (ph_q == PH_W'(phase_of_write_port(k)))) begin
            cp_we[p] = cap_wen_q[k];
            cp_addr[p*ADDR_W +: ADDR_W] = cap_waddr_q[k*ADDR_W +: ADDR_W];
            cp_wd[p*DATA_W +: DATA_W]   = cap_wdata_q[k*DATA_W +: DATA_W];
          end
        end
      end
    end

    tripump_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(PPC)) u_ram (
      .clk  (clk_fast),
      .we   (cp_we),
      .re   (cp_re),
      .addr (cp_addr),
      .wd   (cp_wd),
      .rd   (cp_rd)
    );

    assign rd_data[c*PPC*DATA_W +: PPC*DATA_W] = cp_rd;
  end
endmodule

// File: rtl/tripump_regfile_chk.sv
module tripump_regfile_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int WR_PORTS = 4,
  parameter int RD_PORTS = 8,
  parameter int PHASES   = 3,
  localparam int PH_W    = $clog2(PHASES)
) (
  input logic                       clk_fast,
  input logic                       rst_n,
  input logic [PH_W-1:0]            ph,
  input logic [WR_PORTS-1:0]        cap_wen,
  input logic [WR_PORTS*ADDR_W-1:0] cap_waddr,
  input logic [RD_PORTS*ADDR_W-1:0] cap_raddr,
  input logic [RD_PORTS*DATA_W-1:0] rd_data,
  input logic [RD_PORTS-1:0]        rd_valid
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [RD_PORTS*ADDR_W-1:0] last_raddr;
  always_ff @(posedge clk_fast) begin
    if (ph == '0)
      last_raddr <= cap_raddr;
  end

  // R1: no read result shown while in reset
  always @(posedge clk_fast) begin
    if (!rst_n)
      a_r1_reset_quiet: assert (rd_valid == '0);
  end

  // R2: phase sequence defines the sample/write/read timing
  a_r2_phase_wrap: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph == LAST) |=> (ph == '0));
  a_r2_phase_step: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph != LAST) |=> (ph == $past(ph) + 1'b1));

  // R9: outputs only move on boundary edges
  a_r9_outputs_held: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph != '0) |=> ($stable(rd_data) && $stable(rd_valid)));

  // R6: after filtering, no two surviving writes share an address
  for (genvar k = 0; k < WR_PORTS; k++) begin : g_wk
    for (genvar j = k + 1; j < WR_PORTS; j++) begin : g_wj
      a_r6_single_writer: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (cap_wen[k] && cap_wen[j]) |->
        (cap_waddr[k*ADDR_W +: ADDR_W] != cap_waddr[j*ADDR_W +: ADDR_W]));
    end
  end

  // R4: copies agree when two ports read the same entry
  for (genvar i = 1; i < RD_PORTS; i++) begin : g_agree
    a_r4_copies_agree: assert property (@(posedge clk_fast) disable iff (!rst_n)
      ((ph == PH_W'(1)) && rd_valid[0] && rd_valid[i] &&
       (last_raddr[0 +: ADDR_W] == last_raddr[i*ADDR_W +: ADDR_W])) |->
      (rd_data[0 +: DATA_W] == rd_data[i*DATA_W +: DATA_W]));
  end
endmodule

bind tripump_regfile tripump_regfile_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WR_PORTS (WR_PORTS),
  .RD_PORTS (RD_PORTS),
  .PHASES   (PHASES)
) u_chk (
  .clk_fast  (clk_fast),
  .rst_n     (rst_n),
  .ph        (ph_q),
  .cap_wen   (cap_wen_q),
  .cap_waddr (cap_waddr_q),
  .cap_raddr (cap_raddr_q),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/tripump_regfile_test.sv
`timescale 1ns/1ps
module tripump_regfile_test;
  localparam int AW = 6, DW = 32, NW = 4, NR = 8, NREG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR-1:0]    rd_en = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;
  logic [NR-1:0]    rd_valid;

  tripump_regfile #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_fast (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always #2.5 clk = ~clk;   // 200 MHz fast clock

  int n_checks = 0;
  int n_errors = 0;
  int fe = 0;
  bit done = 1'b0;

  always @(posedge clk) fe <= rst_n ? fe + 1 : 0;

  typedef struct {
    int              tag;
    logic [NR-1:0]   vld;
    logic [NR-1:0]   care;
    logic [NR*DW-1:0] dat;
    string           req;
  } exp_t;
  exp_t q[$];

  // stimulus staging and reference model
  logic [NW-1:0] b_we;
  logic [AW-1:0] b_wa [NW];
  logic [DW-1:0] b_wd [NW];
  logic [NR-1:0] b_re;
  logic [AW-1:0] b_ra [NR];
  logic [DW-1:0] mirror [NREG];
  bit            mknown [NREG];
  logic [DW-1:0] lastd [NR];
  bit            lknown [NR];

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string req, string what, logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares at every boundary, checks stability in between
  logic [NR*DW-1:0] snap_d;
  logic [NR-1:0]    snap_v;
  bit               snap_ok = 1'b0;
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      chk(rd_valid == '0, "R1", "valid during reset", NR*DW'(rd_valid), '0);
    end else if ((fe - 1) % 3 == 0) begin
      int m;
      exp_t it;
      m = (fe - 1) / 3 + 1;
      snap_d = rd_data;
      snap_v = rd_valid;
      snap_ok = 1'b1;
      if (q.size() > 0 && q[0].tag == m) begin
        it = q.pop_front();
        for (int i = 0; i < NR; i++) begin
          chk(rd_valid[i] == it.vld[i], {"R2/R8/", it.req}, $sformatf("port %0d valid", i),
              NR*DW'(rd_valid[i]), NR*DW'(it.vld[i]));
          if (it.care[i])
            chk(rd_data[i*DW +: DW] == it.dat[i*DW +: DW], {"R2/", it.req},
                $sformatf("port %0d data", i), NR*DW'(rd_data[i*DW +: DW]), NR*DW'(it.dat[i*DW +: DW]));
        end
      end else begin
        chk(rd_valid == '0, (m < 3) ? "R1" : "R8", "valid with no read", NR*DW'(rd_valid), '0);
      end
    end else if (snap_ok) begin
      chk(rd_data == snap_d, "R9", "data moved between boundaries", rd_data, snap_d);
      chk(rd_valid == snap_v, "R9", "valid moved between boundaries", NR*DW'(rd_valid), NR*DW'(snap_v));
    end
  end

  task automatic clear();
    b_we = '0;
    b_re = '0;
  endtask

  task automatic rd_same();
    b_re = '1;
    for (int i = 0; i < NR; i++) b_ra[i] = b_wa[i % NW];
  endtask

  task automatic set_wr(logic [NW-1:0] we, int a0, int a1, int a2, int a3, logic [DW-1:0] base);
    b_we = we;
    b_wa[0] = AW'(a0); b_wa[1] = AW'(a1); b_wa[2] = AW'(a2); b_wa[3] = AW'(a3);
    for (int k = 0; k < NW; k++) b_wd[k] = base + DW'(k);
  endtask

  // driver: drive one pipeline cycle, push expected results, advance
  task automatic apply(string req);
    exp_t it;
    for (int k = 0; k < NW; k++) begin
      wr_en[k] = b_we[k];
      wr_addr[k*AW +: AW] = b_wa[k];
      wr_data[k*DW +: DW] = b_wd[k];
    end
    for (int i = 0; i < NR; i++) begin
      rd_en[i] = b_re[i];
      rd_addr[i*AW +: AW] = b_ra[i];
    end
    for (int k = 0; k < NW; k++) begin
      if (b_we[k]) begin
        mirror[b_wa[k]] = b_wd[k];
        mknown[b_wa[k]] = 1'b1;
      end
    end
    it.tag = (fe - 1) / 3 + 1 + 2;
    it.req = req;
    it.vld = b_re;
    it.care = '0;
    it.dat = '0;
    for (int i = 0; i < NR; i++) begin
      if (b_re[i]) begin
        lastd[i] = mirror[b_ra[i]];
        lknown[i] = mknown[b_ra[i]];
      end
      it.care[i] = lknown[i];
      it.dat[i*DW +: DW] = lastd[i];
    end
    q.push_back(it);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_errors++;
    $display("FAIL R2 watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NREG; r++) mknown[r] = 1'b0;
    for (int i = 0; i < NR; i++) begin lknown[i] = 1'b0; lastd[i] = '0; b_ra[i] = '0; end
    for (int k = 0; k < NW; k++) begin b_wa[k] = '0; b_wd[k] = '0; end
    clear();
    #21 rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R4: fill every register, reading a sliding window meanwhile
    for (int b = 0; b < 16; b++) begin
      set_wr('1, 4*b, 4*b+1, 4*b+2, 4*b+3, 32'hC0DE0000 + DW'(b) * 32'h00110101);
      b_re = '1;
      for (int i = 0; i < NR; i++) b_ra[i] = AW'((4*b + i) % NREG);
      apply("R4");
    end

    // R5: read all registers through rotating ports
    for (int s = 0; s < 16; s++) begin
      clear();
      b_re = '1;
      for (int i = 0; i < NR; i++) b_ra[i] = AW'((8*s + (i + s) % 8) % NREG);
      apply("R5");
    end

    // R3: write and read the same registers at one boundary
    set_wr('1, 10, 20, 30, 40, 32'h3EAD0000);
    rd_same();
    apply("R3");

    // R6: colliding writes, read same cycle and next cycle
    set_wr('1, 5, 5, 5, 5, 32'h50000000);     rd_same(); apply("R6");
    set_wr('1, 6, 6, 7, 7, 32'h60000000);     rd_same(); apply("R6");
    set_wr('1, 9, 8, 8, 11, 32'h80000000);    rd_same(); apply("R6");
    set_wr('1, 12, 13, 14, 12, 32'hC0000000); rd_same(); apply("R6");
    set_wr(4'b1011, 15, 16, 15, 16, 32'hF0000000); rd_same(); apply("R6");
    clear(); b_re = '1;
    for (int i = 0; i < NR; i++) b_ra[i] = AW'(5 + i);
    apply("R6");

    // R7: disabled writes leave registers untouched
    set_wr('0, 1, 2, 3, 4, 32'hDEADBEE0);
    rd_same();
    apply("R7");
    clear(); rd_same();
    apply("R7");

    // R8: read enable low holds data and clears valid
    clear(); b_re = '1;
    for (int i = 0; i < NR; i++) b_ra[i] = AW'(20 + i);
    apply("R8");
    set_wr('1, 20, 21, 22, 23, 32'h77770000);
    b_re = '0;
    for (int i = 0; i < NR; i++) b_ra[i] = AW'(40 + i);
    apply("R8");
    clear(); b_re = 8'hA5;
    apply("R8");
    clear();
    apply("R8");

    // R2: randomized mix, narrow address range on odd cycles for overlaps
    for (int n = 0; n < 80; n++) begin
      int span;
      span = (n % 2 == 1) ? 8 : NREG;
      b_we = NW'($urandom);
      for (int k = 0; k < NW; k++) begin
        b_wa[k] = AW'($urandom % span);
        b_wd[k] = DW'($urandom);
      end
      b_re = NR'($urandom);
      for (int i = 0; i < NR; i++) b_ra[i] = AW'($urandom % span);
      apply("R2");
    end

    clear();
    repeat (3) apply("R8");
    repeat (9) @(posedge clk);
    #1;
    chk(q.size() == 0, "R2", "results still pending", NR*DW'(q.size()), '0);
    finish_run();
  end
endmodule